// File: doc/BRIEF.md
# Zero-Block Mask Cache

This block is a small set-associative cache that records, per memory region, which 32-byte blocks hold nothing but zero bytes. A requester presents an address on the lookup port and gets an answer in the same cycle: whether the region is tracked, and whether the addressed block is known to be all zero. A positive answer lets the requester drop the memory transaction before it is issued. A negative answer means the requester sends its normal memory request. The check runs before the request, not alongside it.

The mask contents are maintained through one update port. Returning fill data sets or clears a block's bit according to its content. Store traffic can only keep or restore the bit when the written bytes leave the block provably zero. A global invalidate empties the cache in one cycle. Fetching masks from a backing store on a miss and the data cache itself are outside this block.

Each entry covers a 1 KiB region, which is 32 blocks of 32 bytes, so each entry holds a 32-bit mask. The cache has 16 sets of 4 ways with least-recently-used replacement.

Top module: `zbm_cache`

## Requirements
- R1: After reset, every lookup misses: lk_hit and lk_zero are both 0.
- R2: Address fields are byte offset [4:0], block index [9:5], set index [13:10] and tag [31:14]. A lookup with lk_valid high answers in the same cycle, with lk_hit high exactly when that region is held. With lk_valid low, both outputs are 0.
- R3: lk_zero is 1 only on a hit whose addressed block bit is set. A miss always reports lk_zero = 0.
- R4: A fill (up_is_store = 0) sets the block's bit when all 32 data bytes are zero and clears it otherwise. It ignores up_be and leaves the region's other bits unchanged on a hit.
- R5: A fill to a region that is not held allocates an entry. That entry then hits, with every block except the filled one reporting not zero.
- R6: A store (up_is_store = 1) to a held region writes a new bit that is 1 only when every byte enabled by up_be (bit i covers byte i) is zero and either all 32 bytes are enabled or the bit was already 1.
- R7: A store to a region that is not held allocates nothing; later lookups to that region still miss.
- R8: Allocation uses an invalid way if one exists. Otherwise it evicts the least recently used entry of the set. A lookup hit and an update to a held or allocated region both count as a use. In the same cycle the lookup's use comes first and the update's use second.
- R9: inv_all clears every entry in one cycle, so lookups in the next cycle miss. An update in the same cycle as inv_all is dropped.
- R10: A lookup in the same cycle as an update answers from the state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Region held in the cache |
| lk_zero | output | 1 | Addressed block known all zero |
| up_valid | input | 1 | Update request |
| up_is_store | input | 1 | 1 = store update, 0 = fill from memory |
| up_addr | input | 32 | Update byte address |
| up_data | input | 256 | Block data, byte i at bits [8i+7:8i] |
| up_be | input | 32 | Store byte enables, bit i for byte i |
| inv_all | input | 1 | Invalidate every entry |

## Verification
A wrong mask bit appears directly as a wrong lk_zero on the next lookup of that block. A wrong tag or valid bit shows up as a wrong lk_hit on the first lookup to that region after the faulty update. Wrong recency state stays hidden until a later allocation in the same set evicts the wrong region, which can take several updates to surface. For that reason, the random phase concentrates traffic on a few regions in two sets so that evictions happen often and are observed within a handful of cycles.

// File: rtl/zbm_pkg.sv
package zbm_pkg;

  typedef enum logic {
    UPD_FILL  = 1'b0,
    UPD_STORE = 1'b1
  } zbm_upd_e;

  // New mask bit for one block after an update
  function automatic logic zbm_next_bit(input zbm_upd_e kind,
                                        input logic     old_bit,
                                        input logic     enabled_zero,
                                        input logic     all_enabled);
    if (kind == UPD_FILL) return enabled_zero;
    return enabled_zero && (all_enabled || old_bit);
  endfunction

endpackage

// File: rtl/zbm_way_match.sv
module zbm_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             row_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_vld[w] && (row_tag[w] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // R2: a region is held in at most one way of its set
  a_r2_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/zbm_lru.sv
module zbm_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t0_en,
  input  logic [SET_W-1:0] t0_set,
  input  logic [WAY_W-1:0] t0_way,
  input  logic             t1_en,
  input  logic [SET_W-1:0] t1_set,
  input  logic [WAY_W-1:0] t1_way,
  input  logic [WAYS-1:0]  vic_vld,
  output logic [WAY_W-1:0] vic_way
);

  typedef logic [WAYS-1:0][WAY_W-1:0] age_row_t;

  age_row_t age_q   [SETS];
  age_row_t age_nxt [SETS];
  age_row_t mid_row;
  logic [WAYS-1:0] occ;

  // Make way w the youngest; ways younger than it age by one
  function automatic age_row_t touch(input age_row_t r, input logic [WAY_W-1:0] w);
    age_row_t o;
    o = r;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == w)      o[i] = '0;
      else if (r[i] < r[w])    o[i] = r[i] + 1'b1;
    end
    return o;
  endfunction

  function automatic age_row_t init_row();
    age_row_t o;
    for (int i = 0; i < WAYS; i++) o[i] = WAY_W'(i);
    return o;
  endfunction

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      age_nxt[s] = age_q[s];
      if (t0_en && t0_set == SET_W'(s)) age_nxt[s] = touch(age_nxt[s], t0_way);
      if (t1_en && t1_set == SET_W'(s)) age_nxt[s] = touch(age_nxt[s], t1_way);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= init_row();
    end else begin
      for (int s = 0; s < SETS; s++) age_q[s] <= age_nxt[s];
    end
  end

  // Victim for the update set, seen after the lookup's touch
  always_comb begin
    logic found;
    mid_row = age_q[t1_set];
    if (t0_en && t0_set == t1_set) mid_row = touch(mid_row, t0_way);
    vic_way = '0;
    found   = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (!vic_vld[i] && !found) begin
        vic_way = WAY_W'(i);
        found   = 1'b1;
      end
    if (!found)
      for (int i = 0; i < WAYS; i++)
        if (mid_row[i] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(i);
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < WAYS; i++) occ[age_q[t1_set][i]] = 1'b1;
  end

  // R8: the ages in a set always form a permutation
  a_r8_age_perm: assert property (@(posedge clk) disable iff (!rst_n)
    &occ);

endmodule

// File: rtl/zbm_cache.sv
module zbm_cache
  import zbm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int NBLK      = 32,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int BIX_W  = $clog2(NBLK),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - BIX_W - SET_W,
  localparam int DATA_W = BLK_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_hit,
  output logic                 lk_zero,
  input  logic                 up_valid,
  input  logic                 up_is_store,
  input  logic [ADDR_W-1:0]    up_addr,
  input  logic [DATA_W-1:0]    up_data,
  input  logic [BLK_BYTES-1:0] up_be,
  input  logic                 inv_all
);

  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W+BIX_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [BIX_W-1:0] f_bix(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: BIX_W];
  endfunction

  function automatic logic f_enabled_zero(input logic [DATA_W-1:0] d,
                                          input logic [BLK_BYTES-1:0] be);
    for (int b = 0; b < BLK_BYTES; b++)
      if (be[b] && d[b*8 +: 8] != 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  // Storage
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][NBLK-1:0]  msk_q [SETS];

  // Lookup side
  logic [SET_W-1:0] lk_set;
  logic [BIX_W-1:0] lk_bix;
  logic [WAYS-1:0]  lk_vec;
  logic             lk_match;
  logic [WAY_W-1:0] lk_way;

  assign lk_set = f_set(lk_addr);
  assign lk_bix = f_bix(lk_addr);

  zbm_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n),
    .row_vld(vld_q[lk_set]), .row_tag(tag_q[lk_set]), .key(f_tag(lk_addr)),
    .hit_vec(lk_vec), .hit(lk_match), .hit_way(lk_way)
  );

  assign lk_hit  = lk_valid && lk_match;
  assign lk_zero = lk_hit && msk_q[lk_set][lk_way][lk_bix];

  // Update side
  zbm_upd_e         up_kind;
  logic [SET_W-1:0] up_set;
  logic [BIX_W-1:0] up_bix;
  logic [WAYS-1:0]  up_vec;
  logic             up_hit;
  logic [WAY_W-1:0] up_hit_way;
  logic [WAY_W-1:0] vic_way;
  logic [WAY_W-1:0] up_way;
  logic             up_old_bit;
  logic             up_en_zero;
  logic             up_new_bit;
  logic             up_write;
  logic             up_alloc;
  logic [NBLK-1:0]  up_row;
  logic             fill_zero;

  assign up_kind = up_is_store ? UPD_STORE : UPD_FILL;
  assign up_set  = f_set(up_addr);
  assign up_bix  = f_bix(up_addr);

  zbm_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .clk(clk), .rst_n(rst_n),
    .row_vld(vld_q[up_set]), .row_tag(tag_q[up_set]), .key(f_tag(up_addr)),
    .hit_vec(up_vec), .hit(up_hit), .hit_way(up_hit_way)
  );

  zbm_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .t0_en(lk_hit), .t0_set(lk_set), .t0_way(lk_way),
    .t1_en(up_write), .t1_set(up_set), .t1_way(up_way),
    .vic_vld(vld_q[up_set]), .vic_way(vic_way)
  );

  assign fill_zero  = f_enabled_zero(up_data, {BLK_BYTES{1'b1}});
  assign up_en_zero = (up_kind == UPD_FILL) ? fill_zero : f_enabled_zero(up_data, up_be);
  assign up_old_bit = up_hit && msk_q[up_set][up_hit_way][up_bix];
  assign up_new_bit = zbm_next_bit(up_kind, up_old_bit, up_en_zero, &up_be);
  assign up_write   = up_valid && !inv_all && (up_kind == UPD_FILL || up_hit);
  assign up_alloc   = up_write && !up_hit;
  assign up_way     = up_hit ? up_hit_way : vic_way;

  always_comb begin
    up_row = up_hit ? msk_q[up_set][up_hit_way] : '0;
    up_row[up_bix] = up_new_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (inv_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (up_alloc) begin
      vld_q[up_set][up_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_write) begin
      tag_q[up_set][up_way] <= f_tag(up_addr);
      msk_q[up_set][up_way] <= up_row;
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lk_addr[OFF_W-1:0], up_addr[OFF_W-1:0], lk_vec, up_vec};

  // R9: after an invalidate nothing hits
  a_r9_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_all) && lk_valid |-> !lk_hit);

  // R4: an all-zero fill is visible as zero on the next cycle
  a_r4_fill_zero_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up_valid && !up_is_store && !inv_all && fill_zero) && lk_valid &&
    lk_addr[ADDR_W-1:OFF_W] == $past(up_addr[ADDR_W-1:OFF_W]) |-> lk_hit && lk_zero);

  // R4: a non-zero fill is visible as a non-zero hit on the next cycle
  a_r4_fill_nonzero_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up_valid && !up_is_store && !inv_all && !fill_zero) && lk_valid &&
    lk_addr[ADDR_W-1:OFF_W] == $past(up_addr[ADDR_W-1:OFF_W]) |-> lk_hit && !lk_zero);

  // R7: a store miss does not allocate
  a_r7_store_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up_valid && up_is_store && !up_hit && !inv_all) && lk_valid &&
    lk_addr[ADDR_W-1:OFF_W+BIX_W] == $past(up_addr[ADDR_W-1:OFF_W+BIX_W]) |-> !lk_hit);

  // R6: a partial store onto a non-zero block cannot make it zero
  a_r6_partial_store_keeps_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up_valid && up_is_store && up_hit && !inv_all && !up_old_bit && !(&up_be)) &&
    lk_valid && lk_addr[ADDR_W-1:OFF_W] == $past(up_addr[ADDR_W-1:OFF_W]) |-> !lk_zero);

endmodule

// File: tb/zbm_cache_tb.sv
module zbm_cache_tb_top;

  logic         clk;
  logic         rst_n;
  logic         lk_valid;
  logic [31:0]  lk_addr;
  logic         lk_hit;
  logic         lk_zero;
  logic         up_valid;
  logic         up_is_store;
  logic [31:0]  up_addr;
  logic [255:0] up_data;
  logic [31:0]  up_be;
  logic         inv_all;

  int n_cmp = 0;
  int n_bad = 0;

  zbm_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_zero(lk_zero),
    .up_valid(up_valid), .up_is_store(up_is_store), .up_addr(up_addr),
    .up_data(up_data), .up_be(up_be), .inv_all(inv_all)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model: per set a recency list of region numbers, front = newest
  int       mdl_q [16][$];
  bit [31:0] mdl_mask [int];

  function automatic int m_find(int region);
    int s = region % 16;
    for (int i = 0; i < mdl_q[s].size(); i++)
      if (mdl_q[s][i] == region) return i;
    return -1;
  endfunction

  function automatic void m_use(int region, int idx);
    int s = region % 16;
    mdl_q[s].delete(idx);
    mdl_q[s].push_front(region);
  endfunction

  function automatic bit enabled_bytes_zero(logic [255:0] d, logic [31:0] be);
    for (int b = 0; b < 32; b++)
      if (be[b] && d[b*8 +: 8] != 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic lkv, input logic [31:0] lka,
                      input logic upv, input logic ups, input logic [31:0] upa,
                      input logic [255:0] upd, input logic [31:0] upbe,
                      input logic inv, input string req);
    bit e_hit, e_zero;
    int lreg, lidx, ureg, uidx, ublk;
    @(negedge clk);
    lk_valid = lkv; lk_addr = lka;
    up_valid = upv; up_is_store = ups; up_addr = upa; up_data = upd; up_be = upbe;
    inv_all = inv;
    #5;
    lreg = int'(lka >> 10);
    lidx = m_find(lreg);
    e_hit  = lkv && (lidx >= 0);
    e_zero = e_hit && mdl_mask[lreg][(lka >> 5) & 31];
    chk(lk_hit,  e_hit,  req, "lk_hit");
    chk(lk_zero, e_zero, req, "lk_zero");
    // state change at the coming edge
    if (inv) begin
      for (int s = 0; s < 16; s++) mdl_q[s].delete();
      mdl_mask.delete();
    end else begin
      if (e_hit) m_use(lreg, lidx);
      if (upv) begin
        ureg = int'(upa >> 10);
        ublk = int'((upa >> 5) & 32'd31);
        uidx = m_find(ureg);
        if (!ups) begin
          if (uidx >= 0) m_use(ureg, uidx);
          else begin
            mdl_q[ureg % 16].push_front(ureg);
            mdl_mask[ureg] = '0;
            if (mdl_q[ureg % 16].size() > 4) mdl_mask.delete(mdl_q[ureg % 16].pop_back());
          end
          mdl_mask[ureg][ublk] = enabled_bytes_zero(upd, 32'hFFFF_FFFF);
        end else if (uidx >= 0) begin
          mdl_mask[ureg][ublk] = enabled_bytes_zero(upd, upbe) &&
                                 ((upbe == 32'hFFFF_FFFF) || mdl_mask[ureg][ublk]);
          m_use(ureg, uidx);
        end
      end
    end
  endtask

  function automatic logic [31:0] ad(int region, int blk);
    return 32'((region << 10) | (blk << 5));
  endfunction

  task automatic look(int region, int blk, string req);
    step(1'b1, ad(region, blk), 1'b0, 1'b0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic fill(int region, int blk, logic [255:0] d, string req);
    step(1'b0, '0, 1'b1, 1'b0, ad(region, blk), d, '0, 1'b0, req);
  endtask

  task automatic store(int region, int blk, logic [255:0] d, logic [31:0] be, string req);
    step(1'b0, '0, 1'b1, 1'b1, ad(region, blk), d, be, 1'b0, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [255:0] nz;
    nz = '0; nz[8*7 +: 8] = 8'h5A;
    rst_n = 1'b0; lk_valid = 0; lk_addr = '0; up_valid = 0; up_is_store = 0;
    up_addr = '0; up_data = '0; up_be = '0; inv_all = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(0, 0, "R1");
    look(16, 3, "R1");
    // R2: lookup strobe low gives no answer
    step(1'b0, ad(0, 0), 1'b0, 1'b0, '0, '0, '0, 1'b0, "R2");
    // R4 / R5: fills
    fill(0, 3, '0, "R4");
    look(0, 3, "R4");
    look(0, 4, "R5");
    look(1, 3, "R3");
    fill(0, 3, nz, "R4");
    look(0, 3, "R4");
    // R6: stores
    fill(0, 5, '0, "R6");
    store(0, 5, '0, 32'h0000_000F, "R6");
    look(0, 5, "R6");
    store(0, 5, 256'hAA, 32'h0000_0001, "R6");
    look(0, 5, "R6");
    store(0, 5, '0, 32'h0000_00FF, "R6");
    look(0, 5, "R6");
    store(0, 5, '0, 32'hFFFF_FFFF, "R6");
    look(0, 5, "R6");
    // R7: store miss
    store(48, 2, '0, 32'hFFFF_FFFF, "R7");
    look(48, 2, "R7");
    // R8: replacement within set 0
    fill(16, 1, '0, "R8");
    fill(32, 1, '0, "R8");
    fill(64, 1, '0, "R8");
    look(0, 5, "R8");
    fill(80, 1, '0, "R8");
    look(16, 1, "R8");
    look(0, 5, "R8");
    look(32, 1, "R8");
    // R8: lookup use ordered before update in the same cycle
    step(1'b1, ad(64, 1), 1'b1, 1'b0, ad(96, 0), '0, '0, 1'b0, "R8");
    look(64, 1, "R8");
    look(0, 5, "R8");
    // R10: same-cycle lookup and fill
    step(1'b1, ad(64, 7), 1'b1, 1'b0, ad(64, 7), '0, '0, 1'b0, "R10");
    look(64, 7, "R10");
    // R9: invalidate beats a simultaneous fill
    step(1'b0, '0, 1'b1, 1'b0, ad(2, 2), '0, '0, 1'b1, "R9");
    look(64, 7, "R9");
    look(2, 2, "R9");

    // R2 / R3 / R8 random traffic on two sets
    for (int n = 0; n < 3000; n++) begin
      int regs [7] = '{0, 16, 32, 48, 64, 1, 17};
      logic [255:0] d;
      logic [31:0] be;
      d = '0;
      if ($urandom_range(1, 0) == 1) d[8*$urandom_range(31, 0) +: 8] = 8'($urandom_range(255, 1));
      be = ($urandom_range(3, 0) == 0) ? 32'hFFFF_FFFF : $urandom;
      step($urandom_range(1, 0) == 1, ad(regs[$urandom_range(6, 0)], $urandom_range(3, 0)),
           $urandom_range(1, 0) == 1, $urandom_range(2, 0) == 0,
           ad(regs[$urandom_range(6, 0)], $urandom_range(3, 0)), d, be,
           $urandom_range(63, 0) == 0, "R2");
    end

    summary();
    $finish;
  end

endmodule